// File: doc/BRIEF.md
# Aliased General-Purpose Register File

This block holds eight 32-bit general-purpose registers. It has two combinational read ports and one write port that commits on the clock edge. Every port takes a 3-bit register code and a 2-bit access size. The size selects the full 32-bit register, its low 16 bits, or one byte.

In byte mode, codes 0 to 3 select bits 7:0 of registers 0 to 3, and codes 4 to 7 select bits 15:8 of those same four registers. Reads return the selected slice zero-extended to 32 bits. A narrow write merges into the stored value and leaves every bit outside the slice as it was.

A read that targets the register being written in the same cycle sees the merged value that will be stored at the next edge. An execution stage can therefore consume a result without waiting a cycle.

Top module: `gpr_alias_file`

## Requirements
- R1: The size encoding is 2'b00 byte, 2'b01 word, and 2'b10 or 2'b11 doubleword. A doubleword read with code n (0..7) returns all 32 bits of register n.
- R2: A word read with code n returns bits 15:0 of register n, with bits 31:16 of the result zero.
- R3: A byte read with code 0..3 returns bits 7:0 of register 0..3, with bits 31:8 of the result zero.
- R4: A byte read with code 4..7 returns bits 15:8 of register (code-4), with bits 31:8 of the result zero.
- R5: A doubleword write replaces all 32 bits of register n with the write data.
- R6: A word write with code n loads data bits 15:0 into bits 15:0 of register n and keeps bits 31:16.
- R7: A byte write with code 0..3 loads data bits 7:0 into bits 7:0 of register 0..3 and keeps bits 31:8.
- R8: A byte write with code 4..7 loads data bits 7:0 into bits 15:8 of register (code-4) and keeps bits 31:16 and 7:0.
- R9: A write changes no register other than its target.
- R10: When either read port targets the register being written in that cycle, it returns the slice of the merged value that the write will store.
- R11: An active-low reset clears all registers to zero at once, without waiting for a clock edge.
- R12: With the write enable low, no register changes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Write enable |
| wr_code | input | 3 | Write register code |
| wr_size | input | 2 | Write access size |
| wr_data | input | 32 | Write data, right-aligned |
| ra_code | input | 3 | Read port A register code |
| ra_size | input | 2 | Read port A access size |
| ra_data | output | 32 | Read port A data, zero-extended |
| rb_code | input | 3 | Read port B register code |
| rb_size | input | 2 | Read port B access size |
| rb_data | output | 32 | Read port B data, zero-extended |

## Verification
A corrupted register or a wrong merge stays hidden until a read port addresses that register. The bench therefore follows each narrow write with a full-width read of the target, and with reads of neighbouring registers. A fault in the bypass shows in the same cycle as the write, before the clock edge. A fault in the merge shows one cycle later, on the first read after the edge.

// File: rtl/gpr_pkg.sv
package gpr_pkg;
  typedef enum logic [1:0] {
    SZ_BYTE = 2'b00,
    SZ_WORD = 2'b01,
    SZ_DW   = 2'b10,
    SZ_DWX  = 2'b11
  } gpr_size_e;
endpackage

// File: rtl/gpr_target.sv
// Maps a register code and access size onto a storage index and a high-byte flag.
module gpr_target #(
  parameter int CODE_W = 3
) (
  input  logic [CODE_W-1:0] code,
  input  logic [1:0]        size,
  output logic [CODE_W-1:0] idx,
  output logic              hi
);
  always_comb begin
    if (size == gpr_pkg::SZ_BYTE) begin
      idx = {1'b0, code[CODE_W-2:0]};
      hi  = code[CODE_W-1];
    end else begin
      idx = code;
      hi  = 1'b0;
    end
  end
endmodule

// File: rtl/gpr_merge.sv
// Folds write data into the old register value for the addressed slice.
module gpr_merge #(
  parameter int DW = 32
) (
  input  logic [DW-1:0] old_val,
  input  logic [DW-1:0] wdata,
  input  logic [1:0]    size,
  input  logic          hi,
  output logic [DW-1:0] new_val
);
  always_comb begin
    new_val = old_val;
    unique case (size)
      gpr_pkg::SZ_BYTE: begin
        if (hi) new_val[15:8] = wdata[7:0];
        else    new_val[7:0]  = wdata[7:0];
      end
      gpr_pkg::SZ_WORD: new_val[15:0] = wdata[15:0];
      default:          new_val = wdata;
    endcase
  end
endmodule

// File: rtl/gpr_extract.sv
// Selects the addressed slice of a register value and zero-extends it.
module gpr_extract #(
  parameter int DW = 32
) (
  input  logic [DW-1:0] val,
  input  logic [1:0]    size,
  input  logic          hi,
  output logic [DW-1:0] dout
);
  always_comb begin
    dout = '0;
    unique case (size)
      gpr_pkg::SZ_BYTE: dout[7:0]  = hi ? val[15:8] : val[7:0];
      gpr_pkg::SZ_WORD: dout[15:0] = val[15:0];
      default:          dout       = val;
    endcase
  end
endmodule

// File: rtl/gpr_alias_file.sv
module gpr_alias_file #(
  parameter int NREG   = 8,
  parameter int DW     = 32,
  parameter int NRD    = 2,
  localparam int CODE_W = $clog2(NREG)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [CODE_W-1:0] wr_code,
  input  logic [1:0]        wr_size,
  input  logic [DW-1:0]     wr_data,
  input  logic [CODE_W-1:0] ra_code,
  input  logic [1:0]        ra_size,
  output logic [DW-1:0]     ra_data,
  input  logic [CODE_W-1:0] rb_code,
  input  logic [1:0]        rb_size,
  output logic [DW-1:0]     rb_data
);
  logic [DW-1:0]     regs_q [NREG];
  logic [NREG-1:0]   reg_en;
  logic [CODE_W-1:0] w_idx;
  logic              w_hi;
  logic [DW-1:0]     w_merged;

  logic [CODE_W-1:0] rd_code [NRD];
  logic [1:0]        rd_size [NRD];
  logic [DW-1:0]     rd_data [NRD];

  assign rd_code[0] = ra_code;
  assign rd_size[0] = ra_size;
  assign rd_code[1] = rb_code;
  assign rd_size[1] = rb_size;
  assign ra_data    = rd_data[0];
  assign rb_data    = rd_data[1];

  // write path
  gpr_target #(.CODE_W(CODE_W)) u_wtgt (
    .code(wr_code), .size(wr_size), .idx(w_idx), .hi(w_hi)
  );

  gpr_merge #(.DW(DW)) u_merge (
    .old_val(regs_q[w_idx]), .wdata(wr_data), .size(wr_size),
    .hi(w_hi), .new_val(w_merged)
  );

  // storage: one enabled register per entry
  for (genvar i = 0; i < NREG; i++) begin : g_reg
    always_comb reg_en[i] = wr_en && (w_idx == CODE_W'(i));

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)          regs_q[i] <= '0;
      else if (reg_en[i])  regs_q[i] <= w_merged;
    end

    // R7: low-byte write keeps bits above 7
    a_r7_low_byte_keeps: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en && wr_size == gpr_pkg::SZ_BYTE && !wr_code[CODE_W-1] &&
       wr_code == CODE_W'(i))
      |=> regs_q[i][DW-1:8] == $past(regs_q[i][DW-1:8]) &&
          regs_q[i][7:0] == $past(wr_data[7:0]));

    // R8: high-byte alias write touches bits 15:8 only
    if (i < NREG/2) begin : g_hi
      a_r8_high_byte_keeps: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && wr_size == gpr_pkg::SZ_BYTE &&
         wr_code == CODE_W'(i + NREG/2))
        |=> regs_q[i][7:0] == $past(regs_q[i][7:0]) &&
            regs_q[i][DW-1:16] == $past(regs_q[i][DW-1:16]) &&
            regs_q[i][15:8] == $past(wr_data[7:0]));
    end

    // R6: word write keeps the upper half
    a_r6_word_keeps: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en && wr_size == gpr_pkg::SZ_WORD && wr_code == CODE_W'(i))
      |=> regs_q[i][DW-1:16] == $past(regs_q[i][DW-1:16]) &&
          regs_q[i][15:0] == $past(wr_data[15:0]));

    // R5: full write replaces the register
    a_r5_full_write: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en && wr_size[1] && wr_code == CODE_W'(i))
      |=> regs_q[i] == $past(wr_data));

    // R9 / R12: registers not addressed by the write hold
    a_r9_others_hold: assert property (@(posedge clk) disable iff (!rst_n)
      !(wr_en && ((wr_size == gpr_pkg::SZ_BYTE)
                   ? (wr_code[CODE_W-2:0] == (CODE_W-1)'(i) && i < NREG/2)
                   : (wr_code == CODE_W'(i))))
      |=> $stable(regs_q[i]));
  end

  // read ports with same-cycle bypass
  for (genvar p = 0; p < NRD; p++) begin : g_rd
    logic [CODE_W-1:0] r_idx;
    logic              r_hi;
    logic [DW-1:0]     r_src;

    gpr_target #(.CODE_W(CODE_W)) u_rtgt (
      .code(rd_code[p]), .size(rd_size[p]), .idx(r_idx), .hi(r_hi)
    );

    always_comb r_src = (wr_en && w_idx == r_idx) ? w_merged : regs_q[r_idx];

    gpr_extract #(.DW(DW)) u_ext (
      .val(r_src), .size(rd_size[p]), .hi(r_hi), .dout(rd_data[p])
    );

    // R3 / R4: byte reads are zero-extended
    a_r3_byte_zero_ext: assert property (@(posedge clk) disable iff (!rst_n)
      rd_size[p] == gpr_pkg::SZ_BYTE |-> rd_data[p][DW-1:8] == '0);

    // R2: word reads are zero-extended
    a_r2_word_zero_ext: assert property (@(posedge clk) disable iff (!rst_n)
      rd_size[p] == gpr_pkg::SZ_WORD |-> rd_data[p][DW-1:16] == '0);

    // R10: full-width read of the register being fully written sees the new data
    a_r10_bypass_full: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en && wr_size[1] && rd_size[p][1] && wr_code == rd_code[p])
      |-> rd_data[p] == wr_data);
  end
endmodule

// File: tb/test_gpr_alias_file.sv
module test_gpr_alias_file;
  localparam int NV = 18;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        wr_en;
  logic [2:0]  wr_code;
  logic [1:0]  wr_size;
  logic [31:0] wr_data;
  logic [2:0]  ra_code;
  logic [1:0]  ra_size;
  logic [31:0] ra_data;
  logic [2:0]  rb_code;
  logic [1:0]  rb_size;
  logic [31:0] rb_data;

  int checks = 0;
  int fails  = 0;

  always #2.5 clk = ~clk;

  gpr_alias_file i_gpr_alias_file (
    .clk, .rst_n, .wr_en, .wr_code, .wr_size, .wr_data,
    .ra_code, .ra_size, .ra_data, .rb_code, .rb_size, .rb_data
  );

  // {we, wcode, wsize, wdata, racode, rasize, expected ra_data}
  localparam logic [74:0] VEC [NV] = '{
    {1'b1, 3'd0, 2'd2, 32'h11223344, 3'd0, 2'd2, 32'h11223344}, // R10 R5 bypass
    {1'b1, 3'd1, 2'd2, 32'hAABBCCDD, 3'd0, 2'd2, 32'h11223344}, // R1 R5
    {1'b1, 3'd2, 2'd2, 32'h55667788, 3'd1, 2'd1, 32'h0000CCDD}, // R2
    {1'b1, 3'd3, 2'd2, 32'h99AABBCC, 3'd1, 2'd0, 32'h000000DD}, // R3
    {1'b1, 3'd4, 2'd2, 32'hDEADBEEF, 3'd5, 2'd0, 32'h000000CC}, // R4
    {1'b1, 3'd5, 2'd2, 32'h01020304, 3'd4, 2'd2, 32'hDEADBEEF}, // R1
    {1'b1, 3'd6, 2'd2, 32'hCAFEF00D, 3'd5, 2'd1, 32'h00000304}, // R2
    {1'b1, 3'd7, 2'd2, 32'h0BADF00D, 3'd6, 2'd2, 32'hCAFEF00D}, // R1
    {1'b1, 3'd0, 2'd1, 32'hFFFF1234, 3'd7, 2'd2, 32'h0BADF00D}, // R6 write
    {1'b0, 3'd0, 2'd2, 32'hFFFFFFFF, 3'd0, 2'd2, 32'h11221234}, // R6 R12 write
    {1'b1, 3'd2, 2'd0, 32'hFFFFFFAB, 3'd0, 2'd2, 32'h11221234}, // R12 R7 write
    {1'b1, 3'd7, 2'd0, 32'h000000EE, 3'd2, 2'd2, 32'h556677AB}, // R7 R8 write
    {1'b1, 3'd4, 2'd0, 32'h0000005A, 3'd4, 2'd0, 32'h0000005A}, // R10 R8
    {1'b0, 3'd0, 2'd0, 32'h00000000, 3'd3, 2'd2, 32'h99AAEECC}, // R8
    {1'b0, 3'd0, 2'd0, 32'h00000000, 3'd0, 2'd2, 32'h11225A34}, // R8 R9
    {1'b1, 3'd6, 2'd1, 32'h1111BEEF, 3'd6, 2'd2, 32'hCAFEBEEF}, // R10 R6
    {1'b0, 3'd0, 2'd0, 32'h00000000, 3'd4, 2'd1, 32'h0000BEEF}, // R2 code 4
    {1'b0, 3'd0, 2'd0, 32'h00000000, 3'd5, 2'd2, 32'h01020304}  // R9
  };

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic summary();
    $display("  %0d/%0d checks passed", checks - fails, checks);
    $finish;
  endtask

  initial begin
    #1000000;
    checks++;
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    summary();
  end

  initial begin
    rst_n = 1'b0;
    wr_en = 1'b0; wr_code = '0; wr_size = 2'd2; wr_data = '0;
    ra_code = 3'd3; ra_size = 2'd2; rb_code = 3'd7; rb_size = 2'd2;
    repeat (3) @(negedge clk);
    #1;
    check("R11 reset ra", ra_data, 32'h0);
    check("R11 reset rb", rb_data, 32'h0);
    rst_n = 1'b1;

    for (int k = 0; k < NV; k++) begin
      @(negedge clk);
      {wr_en, wr_code, wr_size, wr_data, ra_code, ra_size} = VEC[k][74:32];
      #1;
      check($sformatf("vector %0d (R1..R12)", k), ra_data, VEC[k][31:0]);
    end

    @(negedge clk);
    wr_en = 1'b0;
    rb_code = 3'd3; rb_size = 2'd0;
    ra_code = 3'd0; ra_size = 2'd3;
    #1;
    check("R3 port B low byte code 3", rb_data, 32'h000000CC);
    check("R1 size 2'b11 is full width", ra_data, 32'h11225A34);
    rb_code = 3'd7; rb_size = 2'd0;
    #1;
    check("R4 port B high byte code 7", rb_data, 32'h000000EE);

    @(negedge clk);
    wr_en = 1'b1; wr_code = 3'd1; wr_size = 2'd3; wr_data = 32'h12345678;
    rb_code = 3'd1; rb_size = 2'd2;
    #1;
    check("R10 port B bypass", rb_data, 32'h12345678);
    @(negedge clk);
    wr_en = 1'b0;
    ra_code = 3'd5; ra_size = 2'd0;
    #1;
    check("R5 full write then high byte", ra_data, 32'h00000056);

    ra_code = 3'd2; ra_size = 2'd1; rb_code = 3'd6; rb_size = 2'd1;
    #1;
    check("R2 word read code 2", ra_data, 32'h000077AB);
    check("R2 word read code 6", rb_data, 32'h0000BEEF);

    @(negedge clk);
    rst_n = 1'b0;
    ra_code = 3'd0; ra_size = 2'd2; rb_code = 3'd7; rb_size = 2'd2;
    #1;
    check("R11 async clear ra", ra_data, 32'h0);
    check("R11 async clear rb", rb_data, 32'h0);
    @(negedge clk);
    rst_n = 1'b1;
    ra_code = 3'd6;
    #1;
    check("R11 cleared after release", ra_data, 32'h0);

    summary();
  end
endmodule